// File: doc/BRIEF.md
# Decimal-Modulus Phase Accumulator

This block is a phase accumulator whose counter does not wrap at a power of two. It wraps at a decimal modulus. The modulus is the system clock rate in hertz multiplied by a resolution factor. Because of this, the tuning word is written directly in hertz, or in hertz scaled by the factor. With a factor of 10, a word of 15 produces 1.5 Hz.

On each enabled clock the magnitude of a signed tuning word is added to the counter. When the sum reaches the modulus, the counter keeps the remainder and a one-cycle wrap pulse is raised. An enable input clears the counter when it is low. A load strobe presets the counter from a start value. The clock rate in MHz (10, 40 or 80), the counter width, the word width and the resolution factor are parameters.

Top module: `phase_acc_decimal`

## Requirements
- R1: Let the modulus M be CLK_MHZ × 1,000,000 × RES_FACTOR. On an accumulate cycle the new phase is phase + |fcw| when that sum is below M. Otherwise the new phase is phase + |fcw| − M, which keeps the remainder. With the defaults (M = 80,000,000) a word of 8,000,000 wraps exactly once every 10 cycles.
- R2: After an accumulate cycle that starts from a phase below M, the phase is still below M.
- R3: Only the magnitude of fcw is used. The words +k and −k produce identical outputs. The phase never decreases except on a wrap.
- R4: While enable is low, the phase becomes 0 on the next edge and the wrap pulse stays low. This takes priority over the load strobe.
- R5: The wrap pulse is high for one cycle, in the same cycle that the phase first shows the wrapped value. It is high exactly when an accumulate cycle leaves the phase lower than before.
- R6: With enable high and the load strobe high, the phase takes the start value on the next edge and no wrap pulse is produced, even if an accumulate step would have wrapped.
- R7: A start value at or above M is reduced by subtracting M once. With the defaults, a start value of 100,000,000 loads as 20,000,000.
- R8: A magnitude at or above M is clamped to M − 1. The most negative word has a magnitude of 2^(FCW_W−1), taken as unsigned, and is therefore clamped.
- R9: The synchronous active-high reset makes the phase 0 and the wrap pulse 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; the counter is cleared while low |
| load | input | 1 | Load strobe for the start value |
| start_value | input | WIDTH | Preset value for the counter |
| fcw | input | FCW_W | Signed tuning word, in hertz × RES_FACTOR |
| phase | output | WIDTH | Counter value |
| wrap_pulse | output | 1 | One-cycle pulse on each wrap |

## Verification
Loading and wrapping can both be due in the same cycle. So can clearing and loading. To provoke the first case, the bench runs the counter with a near-modulus word until the next step would wrap, then raises the load strobe in exactly that cycle. To provoke the second, it raises load while enable is low. A behavioural model in the bench applies the priority order clear, then load, then accumulate. It is compared with the phase and the pulse on every clock, so a pulse that leaks through a load, or a load that beats the clear, is reported.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;

    typedef logic [63:0] wide_t;

    typedef enum logic [1:0] {
        MODE_CLEAR,
        MODE_LOAD,
        MODE_RUN
    } acc_mode_e;

    typedef struct packed {
        logic  wrap;
        wide_t value;
    } acc_next_t;

    function automatic wide_t modulus_of(input int mhz, input int factor);
        return 64'(mhz) * 64'd1_000_000 * 64'(factor);
    endfunction

    function automatic wide_t fold_once(input wide_t v, input wide_t m);
        return (v >= m) ? (v - m) : v;
    endfunction

endpackage

// File: rtl/phase_acc_mag.sv
module phase_acc_mag
    import phase_acc_pkg::*;
#(
    parameter int    FCW_W = 32,
    parameter int    WIDTH = 27,
    parameter wide_t MOD   = 64'd80_000_000
) (
    input  logic signed [FCW_W-1:0] fcw,
    output logic        [WIDTH-1:0] mag
);
    logic [FCW_W-1:0] raw_u;
    logic [FCW_W-1:0] abs_u;
    wide_t            abs_w;
    wide_t            lim_w;

    always_comb begin
        raw_u = fcw;
        abs_u = raw_u[FCW_W-1] ? (~raw_u + 1'b1) : raw_u;
        abs_w = 64'(abs_u);
        lim_w = (abs_w >= MOD) ? (MOD - 64'd1) : abs_w;
        mag   = lim_w[WIDTH-1:0];
    end
endmodule

// File: rtl/phase_acc_step.sv
module phase_acc_step
    import phase_acc_pkg::*;
#(
    parameter int    WIDTH = 27,
    parameter wide_t MOD   = 64'd80_000_000
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] inc,
    output acc_next_t        nxt
);
    wide_t sum_w;

    always_comb begin
        sum_w = 64'(cur) + 64'(inc);
        if (sum_w >= MOD) begin
            nxt.wrap  = 1'b1;
            nxt.value = sum_w - MOD;
        end else begin
            nxt.wrap  = 1'b0;
            nxt.value = sum_w;
        end
    end
endmodule

// File: rtl/phase_acc_preset.sv
module phase_acc_preset
    import phase_acc_pkg::*;
#(
    parameter int    WIDTH = 27,
    parameter wide_t MOD   = 64'd80_000_000
) (
    input  logic [WIDTH-1:0] start_value,
    output logic [WIDTH-1:0] preset
);
    wide_t folded;

    always_comb begin
        folded = fold_once(64'(start_value), MOD);
        preset = folded[WIDTH-1:0];
    end
endmodule

// File: rtl/phase_acc_decimal.sv
module phase_acc_decimal
    import phase_acc_pkg::*;
#(
    parameter int CLK_MHZ    = 80,
    parameter int RES_FACTOR = 1,
    parameter int WIDTH      = 27,
    parameter int FCW_W      = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    load,
    input  logic        [WIDTH-1:0] start_value,
    input  logic signed [FCW_W-1:0] fcw,
    output logic        [WIDTH-1:0] phase,
    output logic                    wrap_pulse
);
    localparam wide_t MOD = modulus_of(CLK_MHZ, RES_FACTOR);

    logic [WIDTH-1:0] inc;
    logic [WIDTH-1:0] preset;
    acc_next_t        step;
    acc_mode_e        mode;
    logic [WIDTH-1:0] phase_q;
    logic             wrap_q;

    phase_acc_mag #(.FCW_W(FCW_W), .WIDTH(WIDTH), .MOD(MOD)) u_mag (
        .fcw (fcw),
        .mag (inc)
    );

    phase_acc_step #(.WIDTH(WIDTH), .MOD(MOD)) u_step (
        .cur (phase_q),
        .inc (inc),
        .nxt (step)
    );

    phase_acc_preset #(.WIDTH(WIDTH), .MOD(MOD)) u_preset (
        .start_value (start_value),
        .preset      (preset)
    );

    always_comb begin
        if (!enable)   mode = MODE_CLEAR;
        else if (load) mode = MODE_LOAD;
        else           mode = MODE_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            unique case (mode)
                MODE_CLEAR: begin
                    phase_q <= '0;
                    wrap_q  <= 1'b0;
                end
                MODE_LOAD: begin
                    phase_q <= preset;
                    wrap_q  <= 1'b0;
                end
                default: begin
                    phase_q <= step.value[WIDTH-1:0];
                    wrap_q  <= step.wrap;
                end
            endcase
        end
    end

    assign phase      = phase_q;
    assign wrap_pulse = wrap_q;
endmodule

// File: rtl/phase_acc_decimal_chk.sv
module phase_acc_decimal_chk
    import phase_acc_pkg::*;
#(
    parameter int    WIDTH = 27,
    parameter wide_t MOD   = 64'd80_000_000
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             load,
    input logic [WIDTH-1:0] phase,
    input logic             wrap_pulse
);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (phase == '0) && !wrap_pulse);

    p_load_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        enable && load |=> !wrap_pulse);

    p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        enable && !load && (64'(phase) < MOD) |=> (64'(phase) < MOD));

    p_wrap_drop_r5: assert property (@(posedge clk) disable iff (rst)
        enable && !load |=> (wrap_pulse == (phase < $past(phase))));

    p_monotone_r3: assert property (@(posedge clk) disable iff (rst)
        enable && !load |=> wrap_pulse || (phase >= $past(phase)));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (phase == '0) && !wrap_pulse);
endmodule

bind phase_acc_decimal phase_acc_decimal_chk #(
    .WIDTH (WIDTH),
    .MOD   (phase_acc_pkg::modulus_of(CLK_MHZ, RES_FACTOR))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .load       (load),
    .phase      (phase),
    .wrap_pulse (wrap_pulse)
);

// File: tb/tb_phase_acc_decimal.sv
module tb_phase_acc_decimal;
    localparam int WIDTH = 27;
    localparam int FCW_W = 32;
    localparam longint unsigned MOD = 64'd80_000_000;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    enable = 1'b0;
    logic                    load = 1'b0;
    logic        [WIDTH-1:0] start_value = '0;
    logic signed [FCW_W-1:0] fcw = '0;
    logic        [WIDTH-1:0] phase;
    logic                    wrap_pulse;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    longint unsigned exp_phase = 0;
    bit exp_wrap = 0;
    string tag = "R9";

    always #2.5 clk = ~clk;

    phase_acc_decimal #(.CLK_MHZ(80), .RES_FACTOR(1), .WIDTH(WIDTH), .FCW_W(FCW_W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .load(load),
        .start_value(start_value), .fcw(fcw),
        .phase(phase), .wrap_pulse(wrap_pulse)
    );

    function automatic longint unsigned mag_of(input logic signed [FCW_W-1:0] w);
        longint unsigned m;
        m = w[FCW_W-1] ? longint'(-longint'(w)) : longint'(w);
        if (m >= MOD) m = MOD - 1;
        return m;
    endfunction

    task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One clock: compare at negedge, then drive and advance the model.
    task automatic tick(input bit r, input bit en, input bit ld,
                        input longint unsigned sv, input logic signed [FCW_W-1:0] w);
        longint unsigned s;
        @(negedge clk);
        check(tag, longint'(phase), exp_phase);
        check(tag, longint'(wrap_pulse), longint'(exp_wrap));
        rst = r; enable = en; load = ld; start_value = sv[WIDTH-1:0]; fcw = w;
        if (r || !en) begin
            exp_phase = 0; exp_wrap = 0;
        end else if (ld) begin
            exp_phase = (sv >= MOD) ? sv - MOD : sv; exp_wrap = 0;
        end else begin
            s = exp_phase + mag_of(w);
            if (s >= MOD) begin exp_phase = s - MOD; exp_wrap = 1; end
            else begin exp_phase = s; exp_wrap = 0; end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int wraps;
        tag = "R9";
        for (int i = 0; i < 3; i++) tick(1, 1, 0, 0, 32'sd5);
        // R1 period: 8,000,000 per cycle wraps every 10 cycles
        tag = "R1";
        tick(0, 1, 0, 0, 32'sd8_000_000);
        wraps = 0;
        for (int i = 0; i < 100; i++) begin
            tick(0, 1, 0, 0, 32'sd8_000_000);
            if (wrap_pulse) wraps++;
        end
        check("R1", longint'(wraps), 10);
        // R3 negative word, same magnitude
        tag = "R3";
        for (int i = 0; i < 30; i++) tick(0, 1, 0, 0, -32'sd7_654_321);
        // R2/R5 irregular remainder wraps
        tag = "R5";
        for (int i = 0; i < 40; i++) tick(0, 1, 0, 0, 32'sd33_333_337);
        // R8 clamp and most negative
        tag = "R8";
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 0, 32'sd80_000_000);
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 0, 32'sh8000_0000);
        // R7 fold of oversize start
        tag = "R7";
        tick(0, 1, 1, 100_000_000, 32'sd1);
        tick(0, 1, 0, 0, 32'sd0);
        check("R7", longint'(phase), 20_000_000);
        // R6 load in the cycle a wrap is due
        tag = "R6";
        tick(0, 1, 1, 79_999_990, 32'sd0);
        tick(0, 1, 0, 0, 32'sd0);
        tick(0, 1, 1, 1234, 32'sd50);
        tick(0, 1, 0, 0, 32'sd50);
        check("R6", longint'(wrap_pulse), 0);
        // R4 clear overrides load
        tag = "R4";
        tick(0, 0, 1, 555, 32'sd999);
        tick(0, 0, 0, 0, 32'sd999);
        check("R4", longint'(phase), 0);
        tick(0, 1, 0, 0, -32'sd79_999_999);
        for (int i = 0; i < 6; i++) tick(0, 1, 0, 0, -32'sd79_999_999);
        tag = "R9";
        tick(1, 1, 0, 0, 32'sd3);
        tick(0, 1, 0, 0, 32'sd3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule